// File: doc/BRIEF.md
# Ping-Pong Transmit Packet Buffer

This block holds outgoing packets for a USB serial interface engine in two alternating buffers. A host controller reaches it through a byte-wide register write port, for example the back end of an SPI slave. It streams packet bytes into the buffer it currently owns through a data register. Writing the byte-count register closes the packet: that buffer passes to the bus side and the other buffer becomes the fill target.

The bus side is a valid/ready byte stream. It presents exactly the committed number of bytes of the oldest committed buffer and flags the final one. When that final byte is accepted, the buffer goes back to the free pool. Writes that arrive while both buffers are waiting to be sent are dropped and counted. Bytes past the buffer's capacity are dropped and latch an overflow flag.

Top module: `ppb_tx_buffer`

## Requirements
- R1: After reset `buf_free_o`=1, `tx_valid_o`=0, `overflow_o`=0 and `err_cnt_o`=0.
- R2: A write to address 2 stores `reg_wdata_i` at the next byte position of the buffer being filled. After commit, the bytes leave on `tx_data_o` in the order they were written.
- R3: A write to address 7 commits the buffer with length `reg_wdata_i` (values above 64 count as 64). The stream then carries exactly that many beats, with `tx_last_o`=1 on the final beat only, and a short packet is not padded.
- R4: Each commit switches filling to the other buffer, starting at byte 0. The packet sent is always the one just filled, and bytes left over from a longer earlier packet in the same buffer never appear.
- R5: Data writes beyond 64 bytes in one packet are not stored and set `overflow_o`, which stays at 1 until reset.
- R6: While both buffers are committed and unsent, `buf_free_o`=0. Data and count writes then change nothing, and each one increments `err_cnt_o` (saturating).
- R7: Packets leave in the order they were committed.
- R8: A commit with count 0 produces one beat with `tx_last_o`=1, `tx_empty_o`=1 and `tx_data_o`=0.
- R9: Acceptance of a last beat frees its buffer, and `buf_free_o` is 1 on the following cycle.
- R10: While `tx_valid_o`=1 and `tx_ready_i`=0, the valid signal, data and last flag hold their values into the next cycle.
- R11: Writes to addresses other than 2 and 7 have no effect on stored data, ownership or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| buf_free_o | output | 1 | A buffer is available for filling |
| overflow_o | output | 1 | Sticky byte-overflow flag |
| err_cnt_o | output | 8 | Count of writes rejected while no buffer was free |
| tx_valid_o | output | 1 | Stream beat valid |
| tx_ready_i | input | 1 | Stream beat accepted |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final beat of packet |
| tx_empty_o | output | 1 | Beat carries no byte (zero-length packet) |

## Verification
The bench sends a 31-byte packet into a buffer that earlier held 64 bytes. A design that skipped the buffer swap, or kept the old length, would repeat stale bytes or pad the packet out to 64. It fills both buffers while the stream is stalled and then sends extra data and count writes. A design that accepted them would corrupt or reorder the queued packets, which the scoreboard detects as wrong bytes or an extra beat. It also covers overflow past 64 bytes, zero-length commits, writes to unused addresses, and back-to-back packets under random back-pressure. Those cases catch a dropped or duplicated beat, a missing last flag, and a commit that landed in the wrong buffer.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NBUF   = 2;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/ppb_wr_port.sv
module ppb_wr_port
  import ppb_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned ERR_W      = 8,
  parameter int unsigned DATA_ADDR  = 2,
  parameter int unsigned COUNT_ADDR = 7,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  byte_t             reg_wdata_i,
  input  logic              cpu_full_i,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output byte_t             mem_wdata_o,
  output logic              commit_o,
  output logic [LEN_W-1:0]  commit_len_o,
  output logic              overflow_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic [LEN_W-1:0] wr_ptr_q;
  logic             is_data, is_cnt, at_end;

  assign is_data = reg_we_i && (reg_addr_i == ADDR_W'(DATA_ADDR));
  assign is_cnt  = reg_we_i && (reg_addr_i == ADDR_W'(COUNT_ADDR));
  assign at_end  = (wr_ptr_q == LEN_W'(DEPTH));

  assign mem_we_o     = is_data && !cpu_full_i && !at_end;
  assign mem_idx_o    = wr_ptr_q[IDX_W-1:0];
  assign mem_wdata_o  = reg_wdata_i;
  assign commit_o     = is_cnt && !cpu_full_i;
  assign commit_len_o = (reg_wdata_i > DATA_W'(DEPTH)) ? LEN_W'(DEPTH)
                                                       : LEN_W'(reg_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      overflow_o <= 1'b0;
      err_cnt_o  <= '0;
    end else begin
      if (commit_o)      wr_ptr_q <= '0;
      else if (mem_we_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (is_data && !cpu_full_i && at_end) overflow_o <= 1'b1;
      if ((is_data || is_cnt) && cpu_full_i && (err_cnt_o != '1))
        err_cnt_o <= err_cnt_o + 1'b1;
    end
  end

  a_r5_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ptr_q <= LEN_W'(DEPTH));
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

// File: rtl/ppb_bank.sv
module ppb_bank
  import ppb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  byte_t            wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output byte_t            rdata_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ppb_rd_port.sv
module ppb_rd_port #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avail_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             empty_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             release_o
);
  logic [LEN_W-1:0] rd_ptr_q;
  logic             fire;

  assign valid_o   = avail_i;
  assign empty_o   = (len_i == '0);
  assign last_o    = empty_o || (rd_ptr_q == len_i - LEN_W'(1));
  assign fire      = valid_o && ready_i;
  assign release_o = fire && last_o;
  assign rd_idx_o  = rd_ptr_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_ptr_q <= '0;
    else if (release_o) rd_ptr_q <= '0;
    else if (fire)      rd_ptr_q <= rd_ptr_q + 1'b1;
  end

  a_r3_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_i && !empty_o) |-> (rd_ptr_q < len_i));
  a_r8_zero_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && empty_o) |-> last_o);
  a_r3_ptr_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> (rd_ptr_q == '0));
endmodule

// File: rtl/ppb_tx_buffer.sv
module ppb_tx_buffer
  import ppb_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned ERR_W      = 8,
  parameter int unsigned DATA_ADDR  = 2,
  parameter int unsigned COUNT_ADDR = 7,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic              buf_free_o,
  output logic              overflow_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              tx_empty_o
);
  logic [NBUF-1:0]  full_q;
  logic [LEN_W-1:0] len_q [NBUF];
  logic             cpu_sel_q, rd_sel_q;

  logic             mem_we, commit, release_buf;
  logic [IDX_W-1:0] mem_idx, rd_idx;
  byte_t            mem_wdata;
  logic [LEN_W-1:0] commit_len;
  byte_t            rdata [NBUF];

  assign buf_free_o = !full_q[cpu_sel_q];

  ppb_wr_port #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ERR_W(ERR_W),
    .DATA_ADDR(DATA_ADDR), .COUNT_ADDR(COUNT_ADDR)
  ) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .cpu_full_i   (full_q[cpu_sel_q]),
    .mem_we_o     (mem_we),
    .mem_idx_o    (mem_idx),
    .mem_wdata_o  (mem_wdata),
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .overflow_o   (overflow_o),
    .err_cnt_o    (err_cnt_o)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_bank
    ppb_bank #(.DEPTH(DEPTH)) u_bank (
      .clk_i   (clk_i),
      .we_i    (mem_we && (cpu_sel_q == 1'(g))),
      .waddr_i (mem_idx),
      .wdata_i (mem_wdata),
      .raddr_i (rd_idx),
      .rdata_o (rdata[g])
    );
  end

  ppb_rd_port #(.DEPTH(DEPTH)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .avail_i   (full_q[rd_sel_q]),
    .len_i     (len_q[rd_sel_q]),
    .ready_i   (tx_ready_i),
    .valid_o   (tx_valid_o),
    .last_o    (tx_last_o),
    .empty_o   (tx_empty_o),
    .rd_idx_o  (rd_idx),
    .release_o (release_buf)
  );

  assign tx_data_o = tx_empty_o ? 8'h00 : rdata[rd_sel_q];

  // commit and release never target the same buffer in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q    <= '0;
      cpu_sel_q <= 1'b0;
      rd_sel_q  <= 1'b0;
      for (int i = 0; i < NBUF; i++) len_q[i] <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (commit && (cpu_sel_q == 1'(i))) begin
          full_q[i] <= 1'b1;
          len_q[i]  <= commit_len;
        end else if (release_buf && (rd_sel_q == 1'(i))) begin
          full_q[i] <= 1'b0;
        end
      end
      if (commit)      cpu_sel_q <= ~cpu_sel_q;
      if (release_buf) rd_sel_q  <= ~rd_sel_q;
    end
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));
  a_r6_both_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_free_o |-> (&full_q));
  a_r6_no_commit_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_free_o |-> (!commit && !mem_we));
  a_r9_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_buf |=> buf_free_o);
  a_r7_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_buf |=> (rd_sel_q != $past(rd_sel_q)));
  a_r4_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (cpu_sel_q != $past(cpu_sel_q)));
endmodule

// File: tb/ppb_tx_buffer_tb.sv
`timescale 1ns/1ps
module ppb_tx_buffer_tb;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       buf_free, overflow, tx_valid, tx_last, tx_empty;
  logic       tx_ready = 1'b0;
  logic [7:0] err_cnt, tx_data;

  int total = 0;
  int bad   = 0;
  int mode  = 0;  // 0 always ready, 1 random, 2 stalled
  bit done  = 1'b0;
  logic [9:0]  exp_q [$];
  logic [15:0] lfsr = 16'hACE1;
  bit          stall_prev = 1'b0;
  logic [7:0]  prev_data;
  logic        prev_last;

  always #2.5 clk = ~clk;

  ppb_tx_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .buf_free_o(buf_free), .overflow_o(overflow),
    .err_cnt_o(err_cnt), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_empty_o(tx_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: picks ready for the coming edge, then scores the beat
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: tx_ready = 1'b1;
      1: tx_ready = lfsr[0] | lfsr[3];
      default: tx_ready = 1'b0;
    endcase
    if (rst_n) begin
      if (stall_prev) begin
        check("R10 hold valid", {31'd0, tx_valid}, 32'd1);
        check("R10 hold data/last", {23'd0, tx_last, tx_data}, {23'd0, prev_last, prev_data});
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected beat", 32'd1, 32'd0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check("R2/R3/R4/R7/R8 beat {empty,last,data}",
                {22'd0, tx_empty, tx_last, tx_data}, {22'd0, e});
        end
      end
      stall_prev = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_pkt(input int nwr, input int cnt, input logic [7:0] base);
    while (!buf_free) @(negedge clk);
    if (cnt == 0) exp_q.push_back({1'b1, 1'b1, 8'h00});
    for (int i = 0; i < cnt; i++)
      exp_q.push_back({1'b0, (i == cnt - 1), 8'(base + i)});
    for (int i = 0; i < nwr; i++) wr(A_DATA, 8'(base + i));
    wr(A_CNT, 8'(cnt));
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || tx_valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 buf_free", {31'd0, buf_free}, 32'd1);
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R1 overflow", {31'd0, overflow}, 32'd0);
    check("R1 err_cnt",  {24'd0, err_cnt},  32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 full packets through both buffers
    send_pkt(64, 64, 8'h10); drain();
    send_pkt(64, 64, 8'h80); drain();
    // R4 short packet over stale 64-byte buffer
    send_pkt(31, 31, 8'hC0); drain();
    check("R4 no extra beats", exp_q.size(), 32'd0);

    // R7 R10 back-to-back under random back-pressure
    mode = 1;
    send_pkt(5, 5, 8'h01);
    send_pkt(17, 17, 8'h30);
    send_pkt(1, 1, 8'h77);
    send_pkt(40, 40, 8'h55);
    send_pkt(31, 31, 8'hA0);
    drain();

    // R6 both full: rejected writes
    mode = 2;
    @(negedge clk);
    send_pkt(3, 3, 8'h20);
    send_pkt(4, 4, 8'h90);
    check("R6 buf_free low", {31'd0, buf_free}, 32'd0);
    wr(A_DATA, 8'hEE);
    wr(A_CNT, 8'd1);
    check("R6 err_cnt", {24'd0, err_cnt}, 32'd2);
    check("R6 still full", {31'd0, buf_free}, 32'd0);
    check("R6 queued beats intact", exp_q.size(), 32'd7);
    mode = 0;
    drain();
    check("R9 buf_free after release", {31'd0, buf_free}, 32'd1);
    check("R6 err_cnt after drain", {24'd0, err_cnt}, 32'd2);

    // R5 overflow
    check("R5 overflow not yet", {31'd0, overflow}, 32'd0);
    send_pkt(70, 64, 8'h40);
    check("R5 overflow set", {31'd0, overflow}, 32'd1);
    drain();

    // R8 zero-length
    send_pkt(0, 0, 8'h00);
    drain();
    check("R8 single beat consumed", exp_q.size(), 32'd0);

    // R11 writes to other addresses ignored
    while (!buf_free) @(negedge clk);
    exp_q.push_back({1'b0, 1'b0, 8'h01});
    exp_q.push_back({1'b1 & 1'b0, 1'b1, 8'h02});
    wr(A_DATA, 8'h01);
    wr(3'd5, 8'hAB);
    wr(3'd0, 8'hCD);
    check("R11 no commit on other address", {31'd0, tx_valid}, 32'd0);
    wr(A_DATA, 8'h02);
    wr(A_CNT, 8'd2);
    drain();
    check("R11 err_cnt unchanged", {24'd0, err_cnt}, 32'd2);
    check("R5 overflow sticky", {31'd0, overflow}, 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule